// File: doc/BRIEF.md
# SPI Master/Slave Transceiver

This block is a single serial transfer engine for 8-bit SPI frames. Its role is chosen by software. As a master it makes the serial clock from the system clock through a programmable divider and drives an active-low select. As a slave it follows a clock and select driven in by another device. Clock polarity, clock phase and bit order (MSB or LSB first) can all be chosen, which covers the four standard SPI timing modes in either order.

Software reaches the block through a small register port. Address 0 is control and status, address 1 is transmit data, address 2 is received data and address 3 is the divider. In master mode a write to the transmit register while the block is enabled starts a frame. In slave mode the transmit byte is taken when the external select goes active. When the eighth bit has been captured, the received byte is copied into the receive register. At the same moment a one-cycle pulse appears on `xfer_done` and a sticky done bit is set.

The role, polarity, phase, bit order and divider can be changed only while the block is disabled. The slave path passes its pins through two-flop synchronisers into the system clock domain. For this reason the system clock must run at least four times faster than the external serial clock.

Top module: `spi_duplex_engine`

## Requirements
- R1: After reset every register reads 0: disabled, slave, polarity 0, phase 0, MSB first, divider 0, done clear. `sclk_o` is low, `ss_n_o` is high and `sdo` is low.
- R2: Control register bit 0 is the enable. Bit 1 selects master (1) or slave (0), bit 2 is polarity, bit 3 is phase and bit 8 selects LSB first (1) or MSB first (0). While enable is 1, writes leave bits 1, 2, 3 and 8 and the divider register unchanged, but bit 0 can still be written.
- R3: In master mode a frame gives exactly 8 clock pulses (16 edges) on `sclk_o`, each half period lasting divider+1 system clocks. `ss_n_o` is low for the whole frame, and between frames `sclk_o` rests at the polarity level.
- R4: With bit 8 = 0, bit 7 of the transmit byte goes out first and the first bit received lands in bit 7 of the receive register.
- R5: With bit 8 = 1, bit 0 of the transmit byte goes out first and the first bit received lands in bit 0.
- R6: With phase 0, the first bit is on `sdo` before the first clock edge, and data is captured on leading edges (the edges away from the rest level). With phase 1, data is driven on leading edges and captured on trailing edges. Both polarities work.
- R7: After the eighth capture, the receive register holds the byte and `xfer_done` is high for exactly one cycle. Status bit 15 of address 0 then reads 1 until either a control write with bit 15 = 1 or the start of the next frame clears it.
- R8: In slave mode the block frames on `ss_n_i` and shifts on `sclk_i` edges in all polarity, phase and bit-order settings.
- R9: If `ss_n_i` goes high before the eighth capture, the frame is dropped: there is no done pulse, the done bit stays clear and the receive register is unchanged.
- R10: A write to the transmit register while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control/status, 1 transmit, 2 receive, 3 divider) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| xfer_done | output | 1 | One-cycle pulse when a frame completes |
| sclk_o | output | 1 | Serial clock driven in master mode |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| sclk_i | input | 1 | Serial clock from an external master |
| ss_n_i | input | 1 | Active-low select from an external master |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The hardest situation to reach is a slave frame that is cut short. The external select has to rise after some bits have already crossed the synchronisers but before the eighth capture, and the block must then drop the byte quietly. The bench acts as the external master and deliberately releases select after three bit periods. It then confirms through the register port that no done pulse appeared and that the receive register and done bit are unchanged, and runs a complete frame straight afterwards to show the engine recovered. A second awkward case is a transmit write landing mid-frame. This is reached by writing the transmit register while the bench's slave model is still being clocked, and then checking both the readback and the byte the model collected.

// File: rtl/spi_duplex_engine.sv
module spi_duplex_engine #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        xfer_done,
  output logic        sclk_o,
  output logic        ss_n_o,
  input  logic        sclk_i,
  input  logic        ss_n_i,
  input  logic        sdi,
  output logic        sdo
);
  localparam int RW = 16;

  logic en, mst, cpol, cpha, lsb, done_q;
  logic [DIV_W-1:0] div_q, dcnt;
  logic [7:0] tx_q, rx_q, sh_tx, sh_rx;
  logic [3:0] bcnt, ecnt;
  logic m_busy, sclk_q, s_act, sdo_q;
  logic [2:0] sclk_sy, ss_sy;
  logic [1:0] sdi_sy;

  function automatic logic first_bit(input logic [7:0] b, input logic l);
    return l ? b[0] : b[7];
  endfunction
  function automatic logic [7:0] shifted(input logic [7:0] b, input logic l);
    return l ? {1'b0, b[7:1]} : {b[6:0], 1'b0};
  endfunction

  wire wr_ctl = reg_wr && reg_addr == 2'd0;
  wire wr_tx  = reg_wr && reg_addr == 2'd1;
  wire wr_div = reg_wr && reg_addr == 2'd3;
  wire busy   = m_busy | s_act;
  wire unused_wdata = ^reg_wdata[14:9];

  wire m_start = en && mst && !m_busy && wr_tx;
  wire m_tick  = m_busy && dcnt == div_q;
  wire ss_s    = ss_sy[1];
  wire s_start = en && !mst && ss_sy[2] && !ss_s;
  wire s_edge  = s_act && !ss_s && (sclk_sy[1] != sclk_sy[2]);
  wire lead    = m_busy ? (m_tick && !ecnt[0]) : (s_edge && sclk_sy[1] != cpol);
  wire trail   = m_busy ? (m_tick &&  ecnt[0]) : (s_edge && sclk_sy[1] == cpol);
  wire cap     = (cpha ? trail : lead) && !bcnt[3];
  wire launch  = cpha ? lead : trail;
  wire sdi_in  = mst ? sdi : sdi_sy[1];
  wire last_cap = cap && bcnt == 4'd7;
  wire start   = m_start | s_start;
  wire [7:0] load_b  = m_start ? reg_wdata[7:0] : tx_q;
  wire [7:0] rx_next = lsb ? {sdi_in, sh_rx[7:1]} : {sh_rx[6:0], sdi_in};

  assign sclk_o = (mst && m_busy) ? sclk_q : cpol;
  assign ss_n_o = ~m_busy;
  assign sdo    = sdo_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {done_q, busy, 5'b0, lsb, 4'b0, cpha, cpol, mst, en};
      2'd1:    reg_rdata = {8'h0, tx_q};
      2'd2:    reg_rdata = {8'h0, rx_q};
      default: reg_rdata = RW'(div_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, mst, cpol, cpha, lsb} <= '0;
      div_q <= '0;
      tx_q  <= '0;
    end else begin
      if (wr_ctl) begin
        en <= reg_wdata[0];
        if (!en) {lsb, cpha, cpol, mst} <= {reg_wdata[8], reg_wdata[3:1]};
      end
      if (wr_div && !en) div_q <= reg_wdata[DIV_W-1:0];
      if (wr_tx && !busy) tx_q <= reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      ss_sy   <= '1;
      sdi_sy  <= '0;
      s_act   <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[1:0], sclk_i};
      ss_sy   <= {ss_sy[1:0], ss_n_i};
      sdi_sy  <= {sdi_sy[0], sdi};
      if (!en || mst)    s_act <= 1'b0;
      else if (s_start)  s_act <= 1'b1;
      else if (ss_s || last_cap) s_act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      sclk_q <= 1'b0;
      dcnt   <= '0;
      ecnt   <= '0;
    end else if (!en) begin
      m_busy <= 1'b0;
    end else if (m_start) begin
      m_busy <= 1'b1;
      sclk_q <= cpol;
      dcnt   <= '0;
      ecnt   <= '0;
    end else if (m_tick) begin
      dcnt   <= '0;
      sclk_q <= ~sclk_q;
      ecnt   <= ecnt + 4'd1;
      if (ecnt == 4'd15) m_busy <= 1'b0;
    end else if (m_busy) begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_tx <= '0;
      sh_rx <= '0;
      bcnt  <= '0;
      sdo_q <= 1'b0;
    end else if (start) begin
      bcnt  <= '0;
      sh_rx <= '0;
      sh_tx <= cpha ? load_b : shifted(load_b, lsb);
      sdo_q <= cpha ? 1'b0 : first_bit(load_b, lsb);
    end else begin
      if (launch) begin
        sdo_q <= first_bit(sh_tx, lsb);
        sh_tx <= shifted(sh_tx, lsb);
      end
      if (cap) begin
        sh_rx <= rx_next;
        bcnt  <= bcnt + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q      <= '0;
      done_q    <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= last_cap;
      if (last_cap) begin
        rx_q   <= rx_next;
        done_q <= 1'b1;
      end else if (start || (wr_ctl && reg_wdata[15])) begin
        done_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_duplex_engine_chk.sv
module spi_duplex_engine_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             mst,
  input logic             cpol,
  input logic             cpha,
  input logic             lsb,
  input logic [DIV_W-1:0] div_q,
  input logic [7:0]       tx_q,
  input logic             busy,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             sclk_o,
  input logic             ss_n_o,
  input logic             xfer_done,
  input logic             done_q
);
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en) |-> $stable({mst, cpol, cpha, lsb, div_q})); // R2
  AST_CLOCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk_o) && $stable(cpol)) |-> (!ss_n_o || !$past(ss_n_o))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R7
  AST_DONE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> done_q); // R7
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd1) |=> $stable(tx_q)); // R10
endmodule

bind spi_duplex_engine spi_duplex_engine_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mst(mst), .cpol(cpol), .cpha(cpha),
  .lsb(lsb), .div_q(div_q), .tx_q(tx_q), .busy(busy), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .sclk_o(sclk_o), .ss_n_o(ss_n_o),
  .xfer_done(xfer_done), .done_q(done_q)
);

// File: tb/spi_duplex_engine_test.sv
`timescale 1ns/1ps
module spi_duplex_engine_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 2'd2;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic xfer_done, sclk_o, ss_n_o, sdo;
  logic sclk_i = 0, ss_n_i = 1, sdi = 0;

  spi_duplex_engine uut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, done_n = 0;
  logic [7:0] exp_rx_q[$], exp_pr_q[$];
  logic [7:0] peer_tx, peer_rx;
  bit m_cpol, m_cpha, m_lsb;
  bit peer_on = 0;
  int pi_out, pi_cap, edge_n;
  logic [15:0] rv;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic bsel(input logic [7:0] b, input int i, input bit l);
    return l ? b[i] : b[7-i];
  endfunction
  function automatic int bpos(input int i, input bit l);
    return l ? i : 7 - i;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_addr = 2'd2;
  endtask

  task automatic cfg(input bit ms, input bit po, input bit ph, input bit lf);
    wr(2'd0, 16'h0000);
    sclk_i = po;
    m_cpol = po; m_cpha = ph; m_lsb = lf;
    repeat (4) @(negedge clk);
    wr(2'd0, {7'b0, lf, 4'b0, ph, po, ms, 1'b1});
  endtask

  task automatic wait_empty();
    int t = 0;
    while (exp_rx_q.size() != 0 && t < 2000) begin
      @(negedge clk); t++;
    end
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (rst_n && xfer_done) begin
      done_n++;
      if (exp_rx_q.size() == 0) chk(0, "R7 unexpected done", 1, 0);
      else begin
        logic [7:0] e, p;
        e = exp_rx_q.pop_front();
        p = exp_pr_q.pop_front();
        chk(reg_rdata[7:0] == e, "R4/R5/R6 received byte", reg_rdata[7:0], e);
        chk(peer_rx == p, "R4/R5/R6 byte seen by peer", peer_rx, p);
        @(negedge clk); #1;
        chk(!xfer_done, "R7 done pulse one cycle", xfer_done, 0);
      end
    end
  end

  // bench slave model for master-mode frames
  always @(negedge ss_n_o) begin
    peer_on = 1; pi_out = 0; pi_cap = 0; edge_n = 0; peer_rx = 0;
    if (!m_cpha) begin sdi = bsel(peer_tx, 0, m_lsb); pi_out = 1; end
  end
  always @(sclk_o) begin
    if (peer_on) begin
      edge_n++;
      if ((sclk_o != m_cpol) != m_cpha) begin
        if (pi_cap < 8) peer_rx[bpos(pi_cap, m_lsb)] = sdo;
        pi_cap++;
      end else begin
        if (pi_out < 8) sdi = bsel(peer_tx, pi_out, m_lsb);
        pi_out++;
      end
      if (edge_n == 16) peer_on = 0;
    end
  end

  task automatic master_xfer(input logic [7:0] dut_b, input logic [7:0] pb);
    peer_tx = pb;
    exp_rx_q.push_back(pb);
    exp_pr_q.push_back(dut_b);
    wr(2'd1, {8'h0, dut_b});
    wait_empty();
  endtask

  // bench acting as external master; nb bits then release select
  task automatic ext_master(input logic [7:0] b, input int nb);
    localparam int H = 6;
    peer_rx = 0;
    if (!m_cpha) sdi = bsel(b, 0, m_lsb);
    ss_n_i = 0;
    for (int i = 0; i < nb; i++) begin
      repeat (H) @(negedge clk);
      sclk_i = ~m_cpol;
      if (!m_cpha) peer_rx[bpos(i, m_lsb)] = sdo; else sdi = bsel(b, i, m_lsb);
      repeat (H) @(negedge clk);
      sclk_i = m_cpol;
      if (!m_cpha) begin if (i < 7) sdi = bsel(b, i + 1, m_lsb); end
      else peer_rx[bpos(i, m_lsb)] = sdo;
    end
    repeat (H) @(negedge clk);
    ss_n_i = 1;
    repeat (H) @(negedge clk);
  endtask

  task automatic slave_xfer(input logic [7:0] dut_b, input logic [7:0] mb);
    wr(2'd1, {8'h0, dut_b});
    exp_rx_q.push_back(mb);
    exp_pr_q.push_back(dut_b);
    ext_master(mb, 8);
    wait_empty();
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int t1, t2, dn;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(sclk_o == 0, "R1 sclk_o idle", sclk_o, 0);
    chk(ss_n_o == 1, "R1 ss_n_o idle", ss_n_o, 1);
    chk(sdo == 0, "R1 sdo", sdo, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], rv);
      chk(rv == 0, "R1 register reset value", rv, 0);
    end

    // R3 divider and clock shape, mode 0 MSB first (R4, R6)
    wr(2'd3, 16'd2);
    cfg(1, 0, 0, 0);
    peer_tx = 8'h3C;
    exp_rx_q.push_back(8'h3C); exp_pr_q.push_back(8'hA5);
    wr(2'd1, 16'h00A5);
    @(sclk_o); t1 = $time;
    @(sclk_o); t2 = $time;
    chk(t2 - t1 == 24, "R3 half period = divider+1 clocks", t2 - t1, 24);
    chk(ss_n_o == 0, "R3 select low in frame", ss_n_o, 0);
    wait_empty();
    chk(edge_n == 16, "R3 sixteen clock edges", edge_n, 16);
    chk(sclk_o == 0 && ss_n_o == 1, "R3 idle after frame", {sclk_o, ss_n_o}, 1);

    // R2 lock while enabled
    wr(2'd0, 16'h010D);
    wr(2'd3, 16'd7);
    rd(2'd0, rv);
    chk(rv[8:0] == 9'h003, "R2 fields locked", rv[8:0], 3);
    rd(2'd3, rv);
    chk(rv == 16'd2, "R2 divider locked", rv, 2);

    // R7 done bit and clear paths
    rd(2'd0, rv);
    chk(rv[15] == 1, "R7 done bit set", rv[15], 1);
    wr(2'd0, 16'h8003);
    rd(2'd0, rv);
    chk(rv[15] == 0, "R7 done cleared by write", rv[15], 0);
    master_xfer(8'h5A, 8'h96);
    rd(2'd0, rv);
    chk(rv[15] == 1, "R7 done set again", rv[15], 1);
    peer_tx = 8'h11;
    exp_rx_q.push_back(8'h11); exp_pr_q.push_back(8'h77);
    wr(2'd1, 16'h0077);
    rd(2'd0, rv);
    chk(rv[15] == 0 && rv[14] == 1, "R7 done cleared by next frame", rv[15:14], 1);
    // R10 transmit write mid-frame ignored
    wr(2'd1, 16'h00EE);
    rd(2'd1, rv);
    chk(rv == 16'h0077, "R10 tx write while busy ignored", rv, 16'h77);
    wait_empty();

    // other master modes: R5 LSB first, R6 phases
    wr(2'd0, 16'h0);
    wr(2'd3, 16'd1);
    cfg(1, 1, 1, 1); master_xfer(8'h1E, 8'hC5);
    cfg(1, 1, 0, 0); master_xfer(8'h81, 8'h42);
    cfg(1, 0, 1, 0); master_xfer(8'hD3, 8'h2B);
    cfg(1, 0, 0, 1); master_xfer(8'h0F, 8'hB4);

    // R8 slave mode in several settings
    cfg(0, 0, 0, 0); slave_xfer(8'hA6, 8'h59);
    cfg(0, 1, 1, 1); slave_xfer(8'h35, 8'hCA);
    cfg(0, 0, 1, 0); slave_xfer(8'h72, 8'h8D);
    cfg(0, 1, 0, 1); slave_xfer(8'hE1, 8'h1C);

    // R9 aborted slave frame
    wr(2'd0, {7'b0, 1'b1, 4'b0, 4'b0101} | 16'h8000);
    dn = done_n;
    wr(2'd1, 16'h00C3);
    ext_master(8'h99, 3);
    repeat (10) @(negedge clk);
    chk(done_n == dn, "R9 no done on abort", done_n, dn);
    rd(2'd2, rv);
    chk(rv == 16'h001C, "R9 rx unchanged", rv, 16'h1C);
    rd(2'd0, rv);
    chk(rv[15] == 0, "R9 done bit clear", rv[15], 0);
    slave_xfer(8'h4B, 8'hB7);
    chk(done_n == dn + 1, "R8 recovers after abort", done_n, dn + 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule